// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block judges the address phase of each transaction seen on an I2C bus while the controller acts as a slave. A separate bus front end turns the wires into events and bytes. It delivers one-cycle pulses for START or repeated START and for STOP, and a strobe with each byte it has shifted in. The recognizer compares the address bytes that follow a START with the programmed slave address. It handles either a 7-bit or a 10-bit address. When enabled, it also recognizes the reserved general call and the START byte. For every address byte it returns an acknowledge decision.

Its outputs are a registered match flag, a general-call/START-byte flag and the transfer direction. The data path uses these to decide whether to take part in the rest of the transaction. If an address byte does not fit, the byte is not acknowledged, and every following byte is disregarded until the next START. In 10-bit mode the match waits for both address bytes. A later repeated START carrying the same 10-bit header with the read bit set re-selects the slave without a second address byte.

Top module: `i2c_addr_recog`

## Requirements
- R1: After reset, and in the cycle after any cycle with enable_i low, match_o, gc_o, dir_o and ack_valid_o are 0. While disabled, bytes and events have no effect.
- R2: In 7-bit mode (ten_bit_i=0), a first byte after START whose bits 7:1 equal own_addr_i[6:0] gives ack_valid_o=1 and ack_o=1 one cycle after the byte strobe. match_o is 1 from that cycle on.
- R3: dir_o takes bit 0 of the first byte after every START or repeated START, one cycle after its strobe, and holds it until the next first byte. 1 means the master reads.
- R4: With gc_en_i=1, a first byte of 0x00 (the general call) is acknowledged and sets both match_o and gc_o, in either address mode.
- R5: With gc_en_i=1, a first byte of 0x01 (the START byte) sets gc_o=1 and dir_o=1. It is not acknowledged, and it leaves match_o at 0.
- R6: With gc_en_i=0, first bytes 0x00 and 0x01 are not acknowledged and set neither gc_o nor match_o, provided the own address does not produce them.
- R7: In 10-bit mode, a first byte 11110 a9 a8 0 (a9:a8 = own_addr_i[9:8]) is acknowledged but leaves match_o at 0. match_o rises only when the second byte equals own_addr_i[7:0], and that byte is acknowledged.
- R8: In 10-bit mode, a second byte that differs from own_addr_i[7:0] is not acknowledged and leaves match_o at 0. So does a first byte with a wrong prefix or wrong a9:a8.
- R9: In 10-bit mode, a first byte 11110 a9 a8 1 after a repeated START is acknowledged and sets match_o and dir_o, but only if the previous first byte of the transaction began a 10-bit address that fully matched. Otherwise it is not acknowledged.
- R10: Once an address byte is not acknowledged, or once the address phase has completed, further byte strobes produce no ack_valid_o until the next START.
- R11: A STOP clears match_o, gc_o and the 10-bit history in the next cycle. A START clears match_o and gc_o in the next cycle.
- R12: ack_valid_o is a one-cycle pulse following each address byte strobe. ack_o is never 1 without ack_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Slave recognition enabled |
| ten_bit_i | input | 1 | 1: 10-bit addressing, 0: 7-bit |
| gc_en_i | input | 1 | Recognize general call and START byte |
| own_addr_i | input | 10 | Programmed slave address (7-bit mode uses bits 6:0) |
| start_i | input | 1 | START or repeated START event pulse |
| stop_i | input | 1 | STOP event pulse |
| byte_valid_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte, bit 0 last on the bus |
| match_o | output | 1 | Slave addressed in current transaction |
| gc_o | output | 1 | General call or START byte recognized |
| dir_o | output | 1 | Direction bit of latest first address byte |
| ack_valid_o | output | 1 | Acknowledge decision valid for last address byte |
| ack_o | output | 1 | 1: acknowledge, 0: not acknowledge |

## Verification
Random transactions mix three kinds of first byte: exact copies of the programmed header, single-bit corruptions of it, and the reserved values 0x00 and 0x01. They run under random mode and enable settings. This separates a true compare from one that ignores a bit, and shows the reserved codes taking precedence. Directed 10-bit sequences send a header then a right or wrong second byte. They also send a read header after a repeated START, with and without an earlier full match. This tells a match raised after one byte from one raised after two, and tells a read resume that depends on the earlier match from one that does not. Trailing bytes after a rejection, and STOP and disable in the middle of a transaction, show that the phase tracking and the clearing behave as specified.

// File: rtl/i2c_arec_pkg.sv
package i2c_arec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_SECOND,
    ST_ADDRESSED,
    ST_IGNORE
  } arec_state_e;
endpackage

// File: rtl/i2c_arec_cmp.sv
module i2c_arec_cmp #(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              gc_en_i,
  output logic              gc_hit_o,
  output logic              sbyte_o,
  output logic              hit7_o,
  output logic              hi10_o,
  output logic              lo10_o
);
  localparam int SEV_W = BYTE_W - 1;
  localparam int HI_W  = ADDR_W - BYTE_W;
  localparam int PFX_W = SEV_W - HI_W;
  localparam logic [PFX_W-1:0] PFX = {{(PFX_W-1){1'b1}}, 1'b0};

  logic rsvd_zero;

  assign rsvd_zero = (byte_i[BYTE_W-1:1] == '0);
  assign gc_hit_o  = gc_en_i && rsvd_zero && !byte_i[0];
  assign sbyte_o   = gc_en_i && rsvd_zero && byte_i[0];
  assign hit7_o    = (byte_i[BYTE_W-1:1] == own_addr_i[SEV_W-1:0]);
  // header: prefix, then high address bits, then direction bit
  assign hi10_o    = (byte_i[BYTE_W-1:BYTE_W-PFX_W] == PFX) &&
                     (byte_i[HI_W:1] == own_addr_i[ADDR_W-1:BYTE_W]);
  assign lo10_o    = (byte_i == own_addr_i[BYTE_W-1:0]);
endmodule

// File: rtl/i2c_arec_fsm.sv
module i2c_arec_fsm
  import i2c_arec_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic ten_bit_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic byte_valid_i,
  input  logic dir_bit_i,
  input  logic gc_hit_i,
  input  logic sbyte_i,
  input  logic hit7_i,
  input  logic hi10_i,
  input  logic lo10_i,
  output logic match_o,
  output logic gc_o,
  output logic dir_o,
  output logic ack_valid_o,
  output logic ack_o
);
  arec_state_e state_q, state_d;
  logic match_q, match_d, gc_q, gc_d, dir_q, dir_d;
  logic hist_q, hist_d, ackv_q, ackv_d, ack_q, ack_d;

  always_comb begin
    state_d = state_q;
    match_d = match_q;
    gc_d    = gc_q;
    dir_d   = dir_q;
    hist_d  = hist_q;
    ackv_d  = 1'b0;
    ack_d   = 1'b0;
    if (!enable_i) begin
      state_d = ST_IDLE;
      match_d = 1'b0;
      gc_d    = 1'b0;
      dir_d   = 1'b0;
      hist_d  = 1'b0;
    end else if (stop_i) begin
      state_d = ST_IDLE;
      match_d = 1'b0;
      gc_d    = 1'b0;
      hist_d  = 1'b0;
    end else if (start_i) begin
      state_d = ST_FIRST;
      match_d = 1'b0;
      gc_d    = 1'b0;
    end else if (byte_valid_i) begin
      unique case (state_q)
        ST_FIRST: begin
          ackv_d  = 1'b1;
          dir_d   = dir_bit_i;
          hist_d  = 1'b0;
          state_d = ST_IGNORE;
          if (gc_hit_i) begin
            gc_d = 1'b1; match_d = 1'b1; ack_d = 1'b1; state_d = ST_ADDRESSED;
          end else if (sbyte_i) begin
            gc_d = 1'b1;
          end else if (!ten_bit_i && hit7_i) begin
            match_d = 1'b1; ack_d = 1'b1; state_d = ST_ADDRESSED;
          end else if (ten_bit_i && hi10_i && !dir_bit_i) begin
            ack_d = 1'b1; state_d = ST_SECOND;
          end else if (ten_bit_i && hi10_i && hist_q) begin
            // read resume keeps the history for further restarts
            hist_d = 1'b1; match_d = 1'b1; ack_d = 1'b1; state_d = ST_ADDRESSED;
          end
        end
        ST_SECOND: begin
          ackv_d  = 1'b1;
          state_d = ST_IGNORE;
          if (lo10_i) begin
            match_d = 1'b1; ack_d = 1'b1; hist_d = 1'b1; state_d = ST_ADDRESSED;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      match_q <= 1'b0;
      gc_q    <= 1'b0;
      dir_q   <= 1'b0;
      hist_q  <= 1'b0;
      ackv_q  <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      match_q <= match_d;
      gc_q    <= gc_d;
      dir_q   <= dir_d;
      hist_q  <= hist_d;
      ackv_q  <= ackv_d;
      ack_q   <= ack_d;
    end
  end

  assign match_o     = match_q;
  assign gc_o        = gc_q;
  assign dir_o       = dir_q;
  assign ack_valid_o = ackv_q;
  assign ack_o       = ack_q;

  assert_disabled_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!dir_o && !match_o && !gc_o && !ack_valid_o));
  assert_match_acked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_o) |-> (ack_valid_o && ack_o));
  assert_ten_two_bytes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(match_o) && $past(ten_bit_i) && !gc_o) |->
      ($past(state_q) == ST_SECOND || $past(hist_q)));
  assert_nak_no_match_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_valid_o && !ack_o) |-> !match_o);
  assert_stop_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!match_o && !gc_o));
  assert_ack_qual_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ack_valid_o);
  assert_ackv_cause_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> $past(byte_valid_i));
endmodule

// File: rtl/i2c_addr_recog.sv
module i2c_addr_recog #(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              ten_bit_i,
  input  logic              gc_en_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              match_o,
  output logic              gc_o,
  output logic              dir_o,
  output logic              ack_valid_o,
  output logic              ack_o
);
  logic gc_hit, sbyte, hit7, hi10, lo10;

  i2c_arec_cmp #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_cmp (
    .byte_i     (byte_i),
    .own_addr_i (own_addr_i),
    .gc_en_i    (gc_en_i),
    .gc_hit_o   (gc_hit),
    .sbyte_o    (sbyte),
    .hit7_o     (hit7),
    .hi10_o     (hi10),
    .lo10_o     (lo10)
  );

  i2c_arec_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (enable_i),
    .ten_bit_i    (ten_bit_i),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .byte_valid_i (byte_valid_i),
    .dir_bit_i    (byte_i[0]),
    .gc_hit_i     (gc_hit),
    .sbyte_i      (sbyte),
    .hit7_i       (hit7),
    .hi10_i       (hi10),
    .lo10_i       (lo10),
    .match_o      (match_o),
    .gc_o         (gc_o),
    .dir_o        (dir_o),
    .ack_valid_o  (ack_valid_o),
    .ack_o        (ack_o)
  );

  assert_gc_needs_enable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gc_o) |-> $past(gc_en_i));
  assert_sbyte_no_match_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gc_o && dir_o) |-> !match_o);
endmodule

// File: tb/i2c_addr_recog_tb.sv
module i2c_addr_recog_tb;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n, en, ten, gce, start, stop, bv;
  logic [9:0] own;
  logic [7:0] bdat;
  logic match, gc, dir, ackv, ack;

  int total = 0, fails = 0;
  bit done = 0;

  // reference model: 0 idle, 1 first, 2 second, 3 done/ignore
  int  m_st;
  bit  m_match, m_gc, m_dir, m_hist, e_ackv, e_ack;

  i2c_addr_recog u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .ten_bit_i(ten), .gc_en_i(gce),
    .own_addr_i(own), .start_i(start), .stop_i(stop), .byte_valid_i(bv),
    .byte_i(bdat), .match_o(match), .gc_o(gc), .dir_o(dir),
    .ack_valid_o(ackv), .ack_o(ack)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_flags(input string req);
    chk(req, "match", match, m_match);
    chk(req, "gc", gc, m_gc);
    chk(req, "dir", dir, m_dir);
  endtask

  function automatic bit hdr10(input logic [7:0] b);
    return b[7:3] == 5'b11110 && b[2:1] == own[9:8];
  endfunction

  task automatic model_byte(input logic [7:0] b);
    e_ackv = 0; e_ack = 0;
    if (!en) return;
    if (m_st == 1) begin
      e_ackv = 1; m_dir = b[0]; m_hist = 0; m_st = 3;
      if (gce && b == 8'h00) begin m_gc = 1; m_match = 1; e_ack = 1; end
      else if (gce && b == 8'h01) m_gc = 1;
      else if (!ten && b[7:1] == own[6:0]) begin m_match = 1; e_ack = 1; end
      else if (ten && hdr10(b) && !b[0]) begin e_ack = 1; m_st = 2; end
      else if (ten && hdr10(b) && b[0] && m_hist_prev) begin
        m_hist = 1; m_match = 1; e_ack = 1;
      end
    end else if (m_st == 2) begin
      e_ackv = 1; m_st = 3;
      if (b == own[7:0]) begin m_match = 1; e_ack = 1; m_hist = 1; end
    end
  endtask
  bit m_hist_prev;

  task automatic do_start(input string req);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    if (en) begin m_st = 1; m_match = 0; m_gc = 0; end
    chk_flags(req);
  endtask

  task automatic do_stop(input string req);
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
    m_st = 0; m_match = 0; m_gc = 0; m_hist = 0;
    if (!en) m_dir = 0;
    chk_flags(req);
  endtask

  task automatic do_byte(input string req, input logic [7:0] b);
    @(negedge clk); bv = 1; bdat = b;
    m_hist_prev = m_hist;
    model_byte(b);
    @(negedge clk); bv = 0; bdat = $urandom_range(255);
    chk(req, "ack_valid", ackv, e_ackv);
    chk(req, "ack", ack, e_ack);
    chk_flags(req);
  endtask

  task automatic set_cfg(input bit t, input bit g, input logic [9:0] a);
    @(negedge clk); ten = t; gce = g; own = a;
  endtask

  function automatic logic [7:0] pick_first();
    int k = $urandom_range(9);
    logic [7:0] b;
    if (ten) b = {5'b11110, own[9:8], 1'($urandom_range(1))};
    else     b = {own[6:0], 1'($urandom_range(1))};
    if (k < 2) return 8'h00;
    if (k < 3) return 8'h01;
    if (k < 5) return b ^ (8'h01 << $urandom_range(7, 1));
    if (k < 6) return 8'($urandom_range(255));
    return b;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D2C));
    rst_n = 0; en = 1; ten = 0; gce = 0; own = 10'h05A; start = 0; stop = 0; bv = 0; bdat = 0;
    m_st = 0; m_match = 0; m_gc = 0; m_dir = 0; m_hist = 0; m_hist_prev = 0;
    repeat (3) @(negedge clk);
    chk("R1", "reset match", match, 0);
    chk("R1", "reset gc", gc, 0);
    chk("R1", "reset dir", dir, 0);
    chk("R1", "reset ack_valid", ackv, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 7-bit match write, then R10 trailing data ignored
    set_cfg(0, 0, 10'h05A);
    do_start("R11");
    do_byte("R2", {7'h5A, 1'b0});
    chk("R2", "match direct", match, 1);
    @(negedge clk);
    chk("R12", "ack_valid one cycle", ackv, 0);
    do_byte("R10", 8'hB4);
    // R3 direction on repeated START
    do_start("R11");
    do_byte("R3", {7'h5A, 1'b1});
    chk("R3", "dir read", dir, 1);
    do_stop("R11");
    // R10 mismatch then trailing bytes
    do_start("R11");
    do_byte("R10", {7'h5B, 1'b0});
    do_byte("R10", {7'h5A, 1'b0});
    chk("R10", "no ack_valid after nak", ackv, 0);
    do_stop("R11");

    // R4/R5/R6 reserved codes
    set_cfg(0, 1, 10'h05A);
    do_start("R4"); do_byte("R4", 8'h00);
    chk("R4", "gc set", gc, 1);
    do_start("R5"); do_byte("R5", 8'h01);
    chk("R5", "start byte nak", ack, 0);
    chk("R5", "start byte gc", gc, 1);
    do_stop("R11");
    chk("R11", "gc cleared by stop", gc, 0);
    set_cfg(0, 0, 10'h05A);
    do_start("R6"); do_byte("R6", 8'h00);
    do_start("R6"); do_byte("R6", 8'h01);
    do_stop("R6");

    // R7/R8/R9 10-bit
    set_cfg(1, 1, 10'h2C7);
    do_start("R7"); do_byte("R7", 8'hF4);
    chk("R7", "no match after header", match, 0);
    do_byte("R7", 8'hC7);
    chk("R7", "match after second", match, 1);
    do_start("R9"); do_byte("R9", 8'hF5);
    chk("R9", "read resume match", match, 1);
    do_start("R9"); do_byte("R9", 8'hF5);
    do_stop("R11");
    do_start("R9"); do_byte("R9", 8'hF5);
    chk("R9", "read without history nak", ack, 0);
    do_start("R8"); do_byte("R8", 8'hF4); do_byte("R8", 8'hC6);
    chk("R8", "wrong second byte", match, 0);
    do_start("R8"); do_byte("R8", 8'hF6);
    do_start("R4"); do_byte("R4", 8'h00);
    do_stop("R11");

    // R1 disable mid-transaction
    set_cfg(0, 0, 10'h05A);
    do_start("R1"); do_byte("R1", {7'h5A, 1'b1});
    @(negedge clk); en = 0;
    m_st = 0; m_match = 0; m_gc = 0; m_dir = 0; m_hist = 0;
    @(negedge clk);
    chk_flags("R1");
    do_start("R1"); do_byte("R1", {7'h5A, 1'b1});
    @(negedge clk); en = 1;

    // random phase
    for (int t = 0; t < 400; t++) begin
      set_cfg(1'($urandom_range(1)), 1'($urandom_range(1)), 10'($urandom_range(1023)));
      if (own[6:0] == 7'h00 || own[6:0] == 7'h78 + {5'b0, own[9:8]}) own[6:0] = 7'h33;
      do_start("R2");
      for (int r = 0; r < 1 + $urandom_range(2); r++) begin
        if (r > 0) do_start("R11");
        do_byte("R3", pick_first());
        if ($urandom_range(2) != 0)
          do_byte("R7", ($urandom_range(3) != 0) ? own[7:0] : 8'($urandom_range(255)));
      end
      do_stop("R11");
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule